// File: doc/BRIEF.md
# Serial Memory Read Responder

This block is the target side of a four-wire synchronous serial link (SPI, mode 0). It acts as a small serial memory that understands one command, the plain read. A host preloads the internal byte array through a simple write port. A master then selects the block by pulling chip select low and sends a one-byte command, followed by a 24-bit address. It keeps clocking with filler bytes of its own and collects the memory contents starting at that address. The location advances by one for each byte the master clocks out.

The serial pins are oversampled by the block's system clock. SCK, chip select and MOSI each pass through a synchronizer, and SCK edges are found by comparing consecutive synchronized samples. Because of this, each SCK half-period must last at least four system clock cycles. Only the low `ADDR_BITS` of the received address index the array. The location counter wraps around at the top of the array. Chip select going high at any moment ends the exchange, and the next selection starts again with a command byte.

Top module: `spiReadResponder`

## Requirements
- R1: Frames are 8 bits long and travel most significant bit first. MOSI is captured on the rising SCK edge, and MISO changes only after a falling SCK edge (SCK idles low).
- R2: The first byte after chip select falls is the command. The value 0x03 starts a read.
- R3: The three bytes after a 0x03 command form a 24-bit address, with the high byte received first. Only the low `ADDR_BITS` bits select a location, and the upper bits are ignored.
- R4: While the command byte and the three address bytes are received, MISO returns 0xFF.
- R5: From the fifth byte on, MISO returns the stored bytes at the address, address+1, address+2 and onward, whatever value the master sends on MOSI.
- R6: After the last location (2^`ADDR_BITS` - 1), the next byte streamed comes from location 0.
- R7: A command byte other than 0x03 makes MISO return 0xFF for every byte until chip select rises.
- R8: Chip select rising at any point, including inside a byte, aborts the exchange. The next falling edge of chip select starts again with a command byte.
- R9: When `loadEn` is high at a rising `clk` edge, `loadData` is written into location `loadAddr`.
- R10: While chip select is high, and after reset, MISO is held at 1.
- R11: SCK and MOSI activity while chip select is high has no effect on the next exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Preload write strobe |
| loadAddr | input | ADDR_BITS | Preload location |
| loadData | input | 8 | Preload byte |
| sck | input | 1 | Serial clock from the master, idle low |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
Reads are issued at several addresses. A mid-array start shows that the address bytes are assembled in the right order. A start near the top of the array separates correct wrapping from overrun. An address with non-zero upper bits shows that those bits are truncated, and asymmetric bytes such as 0x80 and 0x01 expose bit-order errors. The master's filler is varied between 0xFF and 0x00 to show that streamed data does not depend on MOSI. Wrong commands, aborts inside the address phase and inside a data byte, and SCK toggling while deselected check that the framing restarts cleanly and that the filler and idle levels hold.

// File: rtl/spiRdPkg.sv
package spiRdPkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_BYTES = 3;
  localparam int FULL_ADDR_W = BYTE_W * ADDR_BYTES;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_STREAM,
    ST_IGNORE
  } rdState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;       // deselected: return shifters to idle
    logic captureBit;  // SCK rose: take one MOSI bit
    logic shiftTx;     // SCK fell inside a byte: next MISO bit
    logic loadTx;      // SCK fell at a byte boundary: new outgoing byte
    logic txFromMem;   // outgoing byte comes from the array
    logic addrShift;   // an address byte completed
    logic addrInc;     // a data byte was fetched: step the location
  } rdCtl_t;

endpackage

// File: rtl/spiRdSync.sv
module spiRdSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic mosiIn,
  output logic sckRise,
  output logic sckFall,
  output logic csActive,
  output logic mosiBit
);

  localparam int LANES = 3;
  // lane order: 0 = mosi, 1 = chip select (idles high), 2 = sck
  localparam logic [LANES-1:0] IDLE_VAL = 3'b010;

  logic [LANES-1:0] rawBus;
  logic [LANES-1:0] syncBus;
  logic             sckPrev;

  assign rawBus = {sckIn, csNIn, mosiIn};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{IDLE_VAL[g]}};
      else       chain <= {chain[STAGES-2:0], rawBus[g]};
    end
    assign syncBus[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= syncBus[2];
  end

  assign csActive = !syncBus[1];
  assign mosiBit  = syncBus[0];
  assign sckRise  = csActive && syncBus[2] && !sckPrev;
  assign sckFall  = csActive && !syncBus[2] && sckPrev;

  // R1: one SCK sample cannot be both a rising and a falling edge
  p_single_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sckRise, sckFall}));

endmodule

// File: rtl/spiRdCtrl.sv
module spiRdCtrl
  import spiRdPkg::*;
#(
  parameter logic [BYTE_W-1:0] OPCODE = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              csActive,
  input  logic [BYTE_W-1:0] rxByte,
  output rdCtl_t            ctl
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [1:0] LAST_ADDR_BYTE = 2'(ADDR_BYTES - 1);

  rdState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       addrBytes;
  logic             byteDone;

  always_comb begin
    byteDone       = csActive && sckRise && (bitCnt == LAST_BIT);
    ctl.clear      = !csActive;
    ctl.captureBit = csActive && sckRise;
    ctl.loadTx     = csActive && sckFall && (bitCnt == '0);
    ctl.shiftTx    = csActive && sckFall && (bitCnt != '0);
    ctl.txFromMem  = (state == ST_STREAM);
    ctl.addrShift  = byteDone && (state == ST_ADDR);
    ctl.addrInc    = csActive && sckFall && (bitCnt == '0) && (state == ST_STREAM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OPCODE;
      bitCnt    <= '0;
      addrBytes <= '0;
    end else if (!csActive) begin
      state     <= ST_OPCODE;
      bitCnt    <= '0;
      addrBytes <= '0;
    end else if (sckRise) begin
      bitCnt <= bitCnt + CNT_W'(1);
      if (byteDone) begin
        unique case (state)
          ST_OPCODE: begin
            state     <= (rxByte == OPCODE) ? ST_ADDR : ST_IGNORE;
            addrBytes <= '0;
          end
          ST_ADDR: begin
            addrBytes <= addrBytes + 2'd1;
            if (addrBytes == LAST_ADDR_BYTE) state <= ST_STREAM;
          end
          default: state <= state;
        endcase
      end
    end
  end

  // R8: deselection always returns the sequencer to command framing
  p_abort_to_opcode_r8: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (state == ST_OPCODE && bitCnt == '0));

  // R7: a rejected command stays rejected until chip select rises
  p_ignore_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE && csActive) |=> (state == ST_IGNORE));

  // R5: streaming continues for as long as the device stays selected
  p_stream_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STREAM && csActive) |=> (state == ST_STREAM));

endmodule

// File: rtl/spiRdData.sv
module spiRdData
  import spiRdPkg::*;
#(
  parameter int ADDR_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rdCtl_t               ctl,
  input  logic                 mosiBit,
  input  logic                 loadEn,
  input  logic [ADDR_BITS-1:0] loadAddr,
  input  logic [BYTE_W-1:0]    loadData,
  output logic [BYTE_W-1:0]    rxByte,
  output logic                 miso
);

  localparam int DEPTH = 1 << ADDR_BITS;

  logic [BYTE_W-1:0]      mem [DEPTH];
  logic [BYTE_W-1:0]      rxShift;
  logic [BYTE_W-1:0]      txShift;
  logic [FULL_ADDR_W-1:0] addrReg;
  logic [BYTE_W-1:0]      memWord;

  // byte completed by the bit arriving now
  assign rxByte  = {rxShift[BYTE_W-2:0], mosiBit};
  assign memWord = mem[addrReg[ADDR_BITS-1:0]];
  assign miso    = txShift[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxShift <= '0;
    else if (ctl.clear)     rxShift <= '0;
    else if (ctl.captureBit) rxShift <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrReg <= '0;
    else if (ctl.clear)    addrReg <= '0;
    else if (ctl.addrShift) addrReg <= {addrReg[FULL_ADDR_W-BYTE_W-1:0], rxByte};
    else if (ctl.addrInc)  addrReg <= addrReg + FULL_ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShift <= FILL_BYTE;
    else if (ctl.clear)   txShift <= FILL_BYTE;
    else if (ctl.loadTx)  txShift <= ctl.txFromMem ? memWord : FILL_BYTE;
    else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
  end

  // R1: MISO moves only on a falling SCK edge or a deselection
  p_miso_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadTx && !ctl.shiftTx && !ctl.clear) |=> $stable(miso));

  // R10: a deselected responder presents a high MISO
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> miso);

endmodule

// File: rtl/spiReadResponder.sv
module spiReadResponder
  import spiRdPkg::*;
#(
  parameter int                ADDR_BITS   = 6,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] OPCODE      = 8'h03
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [ADDR_BITS-1:0] loadAddr,
  input  logic [7:0]           loadData,
  input  logic                 sck,
  input  logic                 csN,
  input  logic                 mosi,
  output logic                 miso
);

  logic              sckRise;
  logic              sckFall;
  logic              csActive;
  logic              mosiBit;
  logic [BYTE_W-1:0] rxByte;
  rdCtl_t            ctl;

  spiRdSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .sckIn    (sck),
    .csNIn    (csN),
    .mosiIn   (mosi),
    .sckRise  (sckRise),
    .sckFall  (sckFall),
    .csActive (csActive),
    .mosiBit  (mosiBit)
  );

  spiRdCtrl #(.OPCODE(OPCODE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sckRise  (sckRise),
    .sckFall  (sckFall),
    .csActive (csActive),
    .rxByte   (rxByte),
    .ctl      (ctl)
  );

  spiRdData #(.ADDR_BITS(ADDR_BITS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .mosiBit  (mosiBit),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .rxByte   (rxByte),
    .miso     (miso)
  );

endmodule

// File: tb/tb_spiReadResponder.sv
`timescale 1ns/1ps
module tb_spiReadResponder;

  localparam int ADDR_BITS = 6;
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int HALF = 6;  // SCK half-period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [ADDR_BITS-1:0] loadAddr = '0;
  logic [7:0] loadData = '0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  logic [7:0] expMem [DEPTH];
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spiReadResponder #(.ADDR_BITS(ADDR_BITS)) dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", what, got, exp);
    end
  endtask

  task automatic preload(input int a, input logic [7:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = ADDR_BITS'(a); loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
    expMem[a] = d;
  endtask

  task automatic sendBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      waitClk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      waitClk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    sendBits(tx, 8, rx);
  endtask

  task automatic deselect();
    waitClk(2);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  // Full read: command, address, then nData streamed bytes
  task automatic readCheck(input logic [23:0] addr, input int nData,
                           input logic [7:0] fill, input string tag);
    logic [7:0] rx;
    csN = 1'b0;
    waitClk(2);
    xfer(8'h03, rx);
    chk(rx, 8'hFF, {tag, " R4 filler during command R2"});
    for (int b = 2; b >= 0; b--) begin
      xfer(addr[b*8 +: 8], rx);
      chk(rx, 8'hFF, {tag, " R4 filler during address R3"});
    end
    for (int k = 0; k < nData; k++) begin
      xfer(fill, rx);
      chk(rx, expMem[(int'(addr) + k) % DEPTH], {tag, " R5 streamed byte"});
    end
    deselect();
  endtask

  task automatic testReset();
    chk({7'd0, miso}, 8'h01, "R10 miso high in reset");
    rstN = 1'b1;
    waitClk(4);
    chk({7'd0, miso}, 8'h01, "R10 miso high after reset");
  endtask

  task automatic testBasic();
    readCheck(24'h000010, 4, 8'hFF, "basic R3");
    readCheck(24'h000005, 3, 8'h00, "mosi zero R5");
  endtask

  task automatic testWrap();
    readCheck(24'h00003E, 4, 8'hFF, "wrap R6");
  endtask

  task automatic testUpperBits();
    readCheck(24'hAB1207, 2, 8'hA5, "upper bits R3");
  endtask

  task automatic testBadOpcode(input logic [7:0] op);
    logic [7:0] rx;
    csN = 1'b0;
    waitClk(2);
    xfer(op, rx);
    chk(rx, 8'hFF, "R7 filler during rejected command");
    for (int k = 0; k < 5; k++) begin
      xfer(8'h00, rx);
      chk(rx, 8'hFF, "R7 rejected command returns 0xFF");
    end
    deselect();
  endtask

  task automatic testAborts();
    logic [7:0] rx;
    // abort inside the address phase
    csN = 1'b0;
    waitClk(2);
    xfer(8'h03, rx);
    xfer(8'h00, rx);
    deselect();
    chk({7'd0, miso}, 8'h01, "R10 miso high after abort");
    readCheck(24'h000020, 2, 8'hFF, "after address abort R8");
    // abort three bits into a data byte
    csN = 1'b0;
    waitClk(2);
    xfer(8'h03, rx);
    xfer(8'h00, rx);
    xfer(8'h00, rx);
    xfer(8'h30, rx);
    sendBits(8'hFF, 3, rx);
    deselect();
    readCheck(24'h000031, 2, 8'hFF, "after mid-byte abort R8");
  endtask

  task automatic testDeselectedActivity();
    for (int k = 0; k < 20; k++) begin
      mosi = k[0];
      sck = ~sck;
      waitClk(HALF);
      chk({7'd0, miso}, 8'h01, "R11 R10 miso idle while deselected");
    end
    sck = 1'b0;
    waitClk(HALF);
    readCheck(24'h00000A, 2, 8'hFF, "after deselected clocks R11");
  endtask

  task automatic testPreloadOrder();
    preload(8'h20 + 8, 8'h80);
    preload(8'h20 + 9, 8'h01);
    preload(8'h20 + 10, 8'h5A);
    readCheck(24'h000028, 3, 8'hFF, "R9 preload and R1 bit order");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    waitClk(5);
    testReset();
    for (int i = 0; i < DEPTH; i++) preload(i, 8'((i * 37 + 5) & 8'hFF));
    testBasic();
    testWrap();
    testUpperBits();
    testBadOpcode(8'h02);
    testBadOpcode(8'h0B);
    testAborts();
    testDeselectedActivity();
    testPreloadOrder();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule